// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-channel datapath of a four-channel DMA controller. It holds a base and a current transfer address and a base and a current transfer count. Each time the bus sequencer reports a completed transfer, it moves the address one step in the direction the channel mode selects. It also lowers the count by one and signals terminal count when the count passes below zero. A host register interface loads the address, count and mode. The controller around the block reads the current values, the sticky terminal-count flag, the self-mask request and the decoded transfer type from its outputs.

A host write to the address or count loads the base copy and the working copy together. Only the working copies are visible at the outputs. With automatic reinitialisation selected, terminal count restores both working copies from the base copies so that the next block can start without software. In cascade service mode the engine leaves its registers untouched. It only forwards the request and acknowledge of a downstream controller. Page extension of the address, bus timing and arbitration between channels belong to other blocks.

Top module: `dma_chan_engine`

## Requirements
- R1: A synchronous active-high reset clears the current address, current count, mode (demand service, verify, incrementing, no reinitialisation), terminal-count pulse, mask request, terminal-count flag, memory strobe enables and cascade outputs to 0.
- R2: A pulse on `host_wr_addr` loads `host_addr_wdata` into both the base and the current address. `cur_addr` shows the value on the cycle after the write edge.
- R3: A pulse on `host_wr_count` loads `host_count_wdata` into both the base and the current count. `cur_count` shows the value on the cycle after the write edge.
- R4: Mode bit 5 sets the address direction. When it is 0, each accepted step adds 1 to `cur_addr`. When it is 1, each step subtracts 1. Both wrap modulo 2^AW.
- R5: Each accepted step lowers `cur_count` by 1. A step taken while `cur_count` is 0 is terminal count: the count wraps to all ones and `tc_pulse` is high for exactly the one cycle after that step. A loaded value N therefore gives N+1 steps.
- R6: When mode bit 4 is 1, a terminal-count step reloads the current address and current count from the base registers instead of stepping them. The base registers are not changed by steps.
- R7: `mask_set` pulses together with `tc_pulse` when mode bit 4 is 0. It stays low on terminal count when mode bit 4 is 1.
- R8: `tc_flag` is set by terminal count and stays set until a `status_clr` pulse clears it. If both happen on the same edge, the flag is set.
- R9: Mode bits 3:2 drive `xfer_type`. Value 01 raises `mem_wr_en`, value 10 raises `mem_rd_en`, and values 00 (verify) and 11 raise neither. These outputs follow a mode write by one cycle.
- R10: Mode bits 7:6 appear on `svc_mode` (00 demand, 01 single, 10 block, 11 cascade). In cascade mode, steps change neither the address nor the count and give no terminal count. `cascade_req` and `cascade_ack` repeat `dreq_in` and `dack_in` one cycle later and are 0 in every other mode.
- R11: A step that arrives on the same edge as any host write (address, count or mode) is ignored, and the host write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_addr | input | 1 | Load base and current address |
| host_addr_wdata | input | AW | Address write data |
| host_wr_count | input | 1 | Load base and current count |
| host_count_wdata | input | CW | Count write data |
| host_wr_mode | input | 1 | Load channel mode |
| host_mode_wdata | input | 8 | Mode byte (bits 1:0 unused here) |
| status_clr | input | 1 | Clear terminal-count flag (status read) |
| step | input | 1 | One transfer completed |
| dreq_in | input | 1 | Downstream request (cascade) |
| dack_in | input | 1 | Acknowledge toward downstream (cascade) |
| cur_addr | output | AW | Current address |
| cur_count | output | CW | Current count |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| mask_set | output | 1 | Request to set this channel's mask bit |
| tc_flag | output | 1 | Sticky terminal-count status flag |
| xfer_type | output | 2 | Transfer type from mode bits 3:2 |
| mem_wr_en | output | 1 | Transfer writes memory |
| mem_rd_en | output | 1 | Transfer reads memory |
| svc_mode | output | 2 | Service mode from mode bits 7:6 |
| cascade_req | output | 1 | Forwarded request in cascade mode |
| cascade_ack | output | 1 | Forwarded acknowledge in cascade mode |

## Verification
Every result of this block appears on the first cycle after the clock edge that sees its cause. That covers the address and count after a write or step, the terminal-count pulse, mask request and flag after the deciding step, the decoded mode outputs after a mode write, and the cascade outputs after the request or acknowledge input. The bench changes inputs at the falling edge, lets exactly one rising edge pass, and compares at the next falling edge. Each table row or directed operation therefore checks the outcome of one edge only. The cascade forwarding test holds the inputs for two edges because a mode change and the forwarded value each take one edge.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int MODE_W = 8;

  typedef enum logic [1:0] {
    SVC_DEMAND  = 2'b00,
    SVC_SINGLE  = 2'b01,
    SVC_BLOCK   = 2'b10,
    SVC_CASCADE = 2'b11
  } svc_mode_e;

  typedef enum logic [1:0] {
    XT_VERIFY   = 2'b00,
    XT_TO_MEM   = 2'b01,
    XT_FROM_MEM = 2'b10,
    XT_ILLEGAL  = 2'b11
  } xfer_type_e;

  // Field order mirrors mode byte bits 7:2.
  typedef struct packed {
    svc_mode_e  svc;
    logic       down;
    logic       autoinit;
    xfer_type_e xt;
  } chan_mode_t;

endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  output chan_mode_t        mode,
  output logic              mem_wr_en,
  output logic              mem_rd_en
);

  chan_mode_t nxt_mode;

  always_comb begin
    nxt_mode = chan_mode_t'(wdata[MODE_W-1:2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= '0;
      mem_wr_en <= 1'b0;
      mem_rd_en <= 1'b0;
    end else if (wr) begin
      mode      <= nxt_mode;
      mem_wr_en <= (nxt_mode.xt == XT_TO_MEM);
      mem_rd_en <= (nxt_mode.xt == XT_FROM_MEM);
    end
  end

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] ldata,
  input  logic          adv,
  input  logic          down,
  input  logic          reload,
  output logic [AW-1:0] cur_addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] base_addr;
  logic [AW-1:0] stepped;

  always_comb begin
    stepped = down ? (cur_addr - ONE) : (cur_addr + ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (load) begin
      base_addr <= ldata;
      cur_addr  <= ldata;
    end else if (adv) begin
      cur_addr  <= reload ? base_addr : stepped;
    end
  end

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] ldata,
  input  logic          adv,
  input  logic          autoinit,
  output logic [CW-1:0] cur_count,
  output logic          tc_hit
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] base_count;

  always_comb begin
    tc_hit = adv && (cur_count == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_count <= '0;
      cur_count  <= '0;
    end else if (load) begin
      base_count <= ldata;
      cur_count  <= ldata;
    end else if (adv) begin
      cur_count  <= (tc_hit && autoinit) ? base_count : (cur_count - ONE);
    end
  end

endmodule

// File: rtl/dma_tc_unit.sv
module dma_tc_unit (
  input  logic clk,
  input  logic rst,
  input  logic tc_hit,
  input  logic autoinit,
  input  logic clr,
  output logic tc_pulse,
  output logic mask_set,
  output logic tc_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_pulse <= 1'b0;
      mask_set <= 1'b0;
      tc_flag  <= 1'b0;
    end else begin
      tc_pulse <= tc_hit;
      mask_set <= tc_hit && !autoinit;
      if (tc_hit)   tc_flag <= 1'b1;
      else if (clr) tc_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_addr,
  input  logic [AW-1:0]     host_addr_wdata,
  input  logic              host_wr_count,
  input  logic [CW-1:0]     host_count_wdata,
  input  logic              host_wr_mode,
  input  logic [MODE_W-1:0] host_mode_wdata,
  input  logic              status_clr,
  input  logic              step,
  input  logic              dreq_in,
  input  logic              dack_in,
  output logic [AW-1:0]     cur_addr,
  output logic [CW-1:0]     cur_count,
  output logic              tc_pulse,
  output logic              mask_set,
  output logic              tc_flag,
  output logic [1:0]        xfer_type,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [1:0]        svc_mode,
  output logic              cascade_req,
  output logic              cascade_ack
);

  chan_mode_t mode;
  logic       is_cascade;
  logic       host_busy;
  logic       adv;
  logic       tc_hit;

  dma_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .wr        (host_wr_mode),
    .wdata     (host_mode_wdata),
    .mode      (mode),
    .mem_wr_en (mem_wr_en),
    .mem_rd_en (mem_rd_en)
  );

  always_comb begin
    is_cascade = (mode.svc == SVC_CASCADE);
    host_busy  = host_wr_addr || host_wr_count || host_wr_mode;
    adv        = step && !is_cascade && !host_busy;
    xfer_type  = mode.xt;
    svc_mode   = mode.svc;
  end

  dma_count_unit #(.CW(CW)) u_count (
    .clk       (clk),
    .rst       (rst),
    .load      (host_wr_count),
    .ldata     (host_count_wdata),
    .adv       (adv),
    .autoinit  (mode.autoinit),
    .cur_count (cur_count),
    .tc_hit    (tc_hit)
  );

  dma_addr_unit #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (host_wr_addr),
    .ldata    (host_addr_wdata),
    .adv      (adv),
    .down     (mode.down),
    .reload   (tc_hit && mode.autoinit),
    .cur_addr (cur_addr)
  );

  dma_tc_unit u_tc (
    .clk      (clk),
    .rst      (rst),
    .tc_hit   (tc_hit),
    .autoinit (mode.autoinit),
    .clr      (status_clr),
    .tc_pulse (tc_pulse),
    .mask_set (mask_set),
    .tc_flag  (tc_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cascade_req <= 1'b0;
      cascade_ack <= 1'b0;
    end else begin
      cascade_req <= is_cascade && dreq_in;
      cascade_ack <= is_cascade && dack_in;
    end
  end

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          host_wr_addr,
  input logic [AW-1:0] host_addr_wdata,
  input logic          host_wr_count,
  input logic [CW-1:0] host_count_wdata,
  input logic          host_wr_mode,
  input logic          step,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_count,
  input logic          tc_pulse,
  input logic          mask_set,
  input logic          tc_flag,
  input logic          mem_wr_en,
  input logic          mem_rd_en,
  input logic [1:0]    svc_mode
);

  logic any_wr;
  assign any_wr = host_wr_addr || host_wr_count || host_wr_mode;

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    host_wr_addr |=> (cur_addr == $past(host_addr_wdata))); // R2

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    host_wr_count |=> (cur_count == $past(host_count_wdata))); // R3

  AST_TC_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> ($past(step) && ($past(cur_count) == '0))); // R5

  AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (tc_pulse && cur_count != '0) |=> !tc_pulse); // R5

  AST_MASK_NEEDS_TC: assert property (@(posedge clk) disable iff (rst)
    mask_set |-> tc_pulse); // R7

  AST_FLAG_ON_TC: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> tc_flag); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr_en && mem_rd_en)); // R9

  AST_CASCADE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (step && svc_mode == 2'b11 && !any_wr) |=> ($stable(cur_addr) && $stable(cur_count) && !tc_pulse)); // R10

  AST_STEP_YIELDS: assert property (@(posedge clk) disable iff (rst)
    (step && host_wr_addr) |=> (cur_addr == $past(host_addr_wdata))); // R11

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .host_wr_addr     (host_wr_addr),
  .host_addr_wdata  (host_addr_wdata),
  .host_wr_count    (host_wr_count),
  .host_count_wdata (host_count_wdata),
  .host_wr_mode     (host_wr_mode),
  .step             (step),
  .cur_addr         (cur_addr),
  .cur_count        (cur_count),
  .tc_pulse         (tc_pulse),
  .mask_set         (mask_set),
  .tc_flag          (tc_flag),
  .mem_wr_en        (mem_wr_en),
  .mem_rd_en        (mem_rd_en),
  .svc_mode         (svc_mode)
);

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;

  localparam int AW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr_addr = 1'b0;
  logic [AW-1:0] host_addr_wdata = '0;
  logic          host_wr_count = 1'b0;
  logic [CW-1:0] host_count_wdata = '0;
  logic          host_wr_mode = 1'b0;
  logic [7:0]    host_mode_wdata = '0;
  logic          status_clr = 1'b0;
  logic          step = 1'b0;
  logic          dreq_in = 1'b0;
  logic          dack_in = 1'b0;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_count;
  logic          tc_pulse, mask_set, tc_flag;
  logic [1:0]    xfer_type;
  logic          mem_wr_en, mem_rd_en;
  logic [1:0]    svc_mode;
  logic          cascade_req, cascade_ack;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  dma_chan_engine #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst(rst),
    .host_wr_addr(host_wr_addr), .host_addr_wdata(host_addr_wdata),
    .host_wr_count(host_wr_count), .host_count_wdata(host_count_wdata),
    .host_wr_mode(host_wr_mode), .host_mode_wdata(host_mode_wdata),
    .status_clr(status_clr), .step(step), .dreq_in(dreq_in), .dack_in(dack_in),
    .cur_addr(cur_addr), .cur_count(cur_count), .tc_pulse(tc_pulse),
    .mask_set(mask_set), .tc_flag(tc_flag), .xfer_type(xfer_type),
    .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .svc_mode(svc_mode),
    .cascade_req(cascade_req), .cascade_ack(cascade_ack)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run exceeded cycle limit, act=%0d exp<=20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests = n_tests + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // op codes: 0 write addr, 1 write count, 2 write mode, 3 step
  task automatic do_op(input logic [1:0] op, input logic [15:0] d);
    host_wr_addr    = (op == 2'd0);
    host_addr_wdata = d;
    host_wr_count   = (op == 2'd1);
    host_count_wdata = d;
    host_wr_mode    = (op == 2'd2);
    host_mode_wdata = d[7:0];
    step            = (op == 2'd3);
    @(negedge clk);
    host_wr_addr = 1'b0; host_wr_count = 1'b0; host_wr_mode = 1'b0; step = 1'b0;
  endtask

  // {op[1:0], data[15:0], exp_addr[15:0], exp_count[15:0], exp_tc, exp_mask}
  localparam int NV = 20;
  localparam logic [51:0] VEC [NV] = '{
    {2'd2, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0}, // mode: inc, no reinit
    {2'd0, 16'h1000, 16'h1000, 16'h0000, 1'b0, 1'b0}, // R2
    {2'd1, 16'h0002, 16'h1000, 16'h0002, 1'b0, 1'b0}, // R3
    {2'd3, 16'h0000, 16'h1001, 16'h0001, 1'b0, 1'b0}, // R4 R5
    {2'd3, 16'h0000, 16'h1002, 16'h0000, 1'b0, 1'b0},
    {2'd3, 16'h0000, 16'h1003, 16'hFFFF, 1'b1, 1'b1}, // R5 third step is tc, R7
    {2'd2, 16'h0020, 16'h1003, 16'hFFFF, 1'b0, 1'b0}, // mode: dec
    {2'd3, 16'h0000, 16'h1002, 16'hFFFE, 1'b0, 1'b0}, // R4 dec
    {2'd0, 16'h0000, 16'h0000, 16'hFFFE, 1'b0, 1'b0},
    {2'd3, 16'h0000, 16'hFFFF, 16'hFFFD, 1'b0, 1'b0}, // R4 wrap down
    {2'd2, 16'h0000, 16'hFFFF, 16'hFFFD, 1'b0, 1'b0},
    {2'd3, 16'h0000, 16'h0000, 16'hFFFC, 1'b0, 1'b0}, // R4 wrap up
    {2'd2, 16'h0010, 16'h0000, 16'hFFFC, 1'b0, 1'b0}, // mode: reinit, inc
    {2'd0, 16'h2000, 16'h2000, 16'hFFFC, 1'b0, 1'b0},
    {2'd1, 16'h0001, 16'h2000, 16'h0001, 1'b0, 1'b0},
    {2'd3, 16'h0000, 16'h2001, 16'h0000, 1'b0, 1'b0},
    {2'd3, 16'h0000, 16'h2000, 16'h0001, 1'b1, 1'b0}, // R6 reload, R7 no mask
    {2'd3, 16'h0000, 16'h2001, 16'h0000, 1'b0, 1'b0}, // R6 base kept
    {2'd2, 16'h00C0, 16'h2001, 16'h0000, 1'b0, 1'b0}, // mode: cascade
    {2'd3, 16'h0000, 16'h2001, 16'h0000, 1'b0, 1'b0}  // R10 frozen, no tc
  };

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 addr", 32'(cur_addr), 32'h0);
    chk("R1 count", 32'(cur_count), 32'h0);
    chk("R1 tc/mask/flag", {29'd0, tc_pulse, mask_set, tc_flag}, 32'h0);
    chk("R1 mode outs", {26'd0, svc_mode, xfer_type, mem_wr_en, mem_rd_en}, 32'h0);
    chk("R1 cascade", {30'd0, cascade_req, cascade_ack}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][51:50], VEC[i][49:34]);
      chk("R2-R7 vec addr", 32'(cur_addr), 32'(VEC[i][33:18]));
      chk("R2-R7 vec count", 32'(cur_count), 32'(VEC[i][17:2]));
      chk("R5 vec tc_pulse", 32'(tc_pulse), 32'(VEC[i][1]));
      chk("R7 vec mask_set", 32'(mask_set), 32'(VEC[i][0]));
    end

    // R8 sticky flag and clear
    chk("R8 flag held", 32'(tc_flag), 32'h1);
    status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
    chk("R8 flag cleared", 32'(tc_flag), 32'h0);
    do_op(2'd2, 16'h0000);
    do_op(2'd1, 16'h0000);
    status_clr = 1'b1; step = 1'b1; @(negedge clk); status_clr = 1'b0; step = 1'b0;
    chk("R8 set wins over clear", 32'(tc_flag), 32'h1);

    // R11 step with host write
    host_wr_addr = 1'b1; host_addr_wdata = 16'h3000; step = 1'b1;
    @(negedge clk);
    host_wr_addr = 1'b0; step = 1'b0;
    chk("R11 addr write wins", 32'(cur_addr), 32'h3000);
    host_wr_count = 1'b1; host_count_wdata = 16'h0005; step = 1'b1;
    @(negedge clk);
    host_wr_count = 1'b0; step = 1'b0;
    chk("R11 count write wins", 32'(cur_count), 32'h0005);
    chk("R11 addr untouched", 32'(cur_addr), 32'h3000);

    // R9 transfer type
    do_op(2'd2, 16'h0004);
    chk("R9 to-memory", {29'd0, xfer_type, mem_wr_en}, {29'd0, 2'b01, 1'b1});
    chk("R9 to-memory rd", 32'(mem_rd_en), 32'h0);
    do_op(2'd2, 16'h0008);
    chk("R9 from-memory", {28'd0, xfer_type, mem_wr_en, mem_rd_en}, {28'd0, 2'b10, 1'b0, 1'b1});
    do_op(2'd2, 16'h000C);
    chk("R9 illegal type", {28'd0, xfer_type, mem_wr_en, mem_rd_en}, {28'd0, 2'b11, 1'b0, 1'b0});

    // R10 service mode and cascade forwarding
    do_op(2'd2, 16'h0080);
    chk("R10 block svc", 32'(svc_mode), 32'h2);
    dreq_in = 1'b1; dack_in = 1'b1;
    @(negedge clk);
    chk("R10 no forward outside cascade", {30'd0, cascade_req, cascade_ack}, 32'h0);
    host_wr_mode = 1'b1; host_mode_wdata = 8'hC0;
    @(negedge clk);
    host_wr_mode = 1'b0;
    chk("R10 cascade svc", 32'(svc_mode), 32'h3);
    @(negedge clk);
    chk("R10 forward in cascade", {30'd0, cascade_req, cascade_ack}, 32'h3);
    dreq_in = 1'b0;
    @(negedge clk);
    chk("R10 forward follows input", {30'd0, cascade_req, cascade_ack}, 32'h1);
    dack_in = 1'b0;
    do_op(2'd2, 16'h0040);
    chk("R10 single svc", 32'(svc_mode), 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule